// File: doc/BRIEF.md
# Banked Scratchpad with Collision Replay

This block is an on-chip scratchpad split into equal, word-wide banks. A vector request carries 32 lanes. Each lane has an active bit, a byte address, a write enable and a 32-bit write value. The block serves the low 16 lanes first and the high 16 lanes after them. A half whose lanes spread over distinct banks is served in one cycle. A half in which several lanes land in one bank is replayed as the fewest collision-free passes, and that bank serves one word per pass.

The request side uses a valid/ready handshake. Ready is high only while the block is idle. Once a request is accepted, ready stays low until the done pulse. A held request waits with its fields stable and is taken on the first cycle that ready is high. The response has no back-pressure. On the done pulse, per-lane read data and the pass count of each half are valid, and they stay unchanged until the next acceptance. Read data is word-wide, and the two lowest address bits do not select anything.

Top module: `banked_spad`

## Requirements
- R1: Byte address bits [5:2] select the bank (word address modulo 16) and bits [9:6] select the row inside it. Bits [1:0] are ignored. A word written at any byte address reads back from every byte address of that word.
- R2: A half whose active lanes all hit distinct banks completes in exactly one pass.
- R3: The pass count of a half equals the largest number of its active lanes that map to one bank. Lanes that give the same word are not merged, so four lanes using byte addresses of one word take four passes.
- R4: Within a half, lanes that share a bank are served in rising lane order. A read therefore sees every write by a lower lane of its half, and for two writes to one word the higher lane's value is the one that remains.
- R5: Inactive lanes count toward no collision and change no memory. Their read data is 0. A half with no active lanes reports 0 passes.
- R6: Lanes 0-15 are handled completely before lanes 16-31. A high-half read sees a low-half write to the same word.
- R7: Ready falls on acceptance. Done is a one-cycle pulse on which ready is high again. Done follows the accepting edge after max(p_lo,1)+max(p_hi,1) clock edges, where p_lo and p_hi are the pass counts of the two halves.
- R8: For 16 lanes at word stride S, a half takes 1 pass when S is odd. For even S it takes gcd(S,16) passes.
- R9: Read data and pass counts hold their values from the done pulse until the next acceptance. Write lanes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_active | input | 32 | Per-lane active bit |
| req_we | input | 32 | Per-lane write enable |
| req_addr | input | 320 | Per-lane byte address, 10 bits per lane, lane 0 lowest |
| req_wdata | input | 1024 | Per-lane write word, 32 bits per lane |
| done | output | 1 | One-cycle pulse when both halves are finished |
| rsp_rdata | output | 1024 | Per-lane read word, 32 bits per lane |
| passes_lo | output | 5 | Passes used by lanes 0-15 |
| passes_hi | output | 5 | Passes used by lanes 16-31 |

## Verification
The hardest case to reach from the ports is the ordering inside a replayed bank. Several passes must run on one bank while reads and writes to the same word are mixed across lanes and across halves. The stimulus first fills memory with known words. It then sends requests in which lanes share a word through different byte offsets, interleaves writes and reads of that word at chosen lane numbers, and places colliding lanes in both halves. A sequential lane-order model predicts each read word, the pass counts from a per-bank tally, and the done latency.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } spad_state_e;
endpackage

// File: rtl/spad_lane_map.sv
module spad_lane_map #(
  parameter int HALF = 16,
  parameter int BW   = 4,
  parameter int RW   = 4,
  localparam int AW  = BW + RW + 2
) (
  input  logic [HALF*AW-1:0] lane_addr,
  output logic [HALF*BW-1:0] lane_bank,
  output logic [HALF*RW-1:0] lane_row
);
  for (genvar l = 0; l < HALF; l++) begin : g_lane
    // the two byte-offset bits are dropped; banks interleave by word
    assign lane_bank[l*BW +: BW] = lane_addr[l*AW + 2 +: BW];
    assign lane_row[l*RW +: RW]  = lane_addr[l*AW + 2 + BW +: RW];
  end
endmodule

// File: rtl/spad_pass_arbiter.sv
module spad_pass_arbiter #(
  parameter int HALF = 16,
  parameter int BW   = 4
) (
  input  logic [HALF-1:0]    pending,
  input  logic [HALF*BW-1:0] lane_bank,
  output logic [HALF-1:0]    grant
);
  logic [HALF-1:0] blocked;

  // a lane waits while any lower pending lane shares its bank
  always_comb begin
    blocked = '0;
    for (int l = 1; l < HALF; l++) begin
      for (int j = 0; j < l; j++) begin
        if (pending[j] && (lane_bank[j*BW +: BW] == lane_bank[l*BW +: BW]))
          blocked[l] = 1'b1;
      end
    end
  end

  assign grant = pending & ~blocked;
endmodule

// File: rtl/spad_bank_array.sv
module spad_bank_array #(
  parameter int NBANKS = 16,
  parameter int DEPTH  = 16,
  parameter int DW     = 32,
  localparam int RW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic [NBANKS-1:0]    bk_we,
  input  logic [NBANKS*RW-1:0] bk_row,
  input  logic [NBANKS*DW-1:0] bk_wdata,
  output logic [NBANKS*DW-1:0] bk_rdata
);
  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (bk_we[b]) mem[bk_row[b*RW +: RW]] <= bk_wdata[b*DW +: DW];
    end

    assign bk_rdata[b*DW +: DW] = mem[bk_row[b*RW +: RW]];
  end
endmodule

// File: rtl/banked_spad.sv
module banked_spad
  import spad_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int NBANKS = 16,
  parameter int DEPTH  = 16,
  parameter int DW     = 32,
  localparam int HALF  = LANES / 2,
  localparam int BW    = $clog2(NBANKS),
  localparam int RW    = $clog2(DEPTH),
  localparam int AW    = BW + RW + 2,
  localparam int PCW   = $clog2(HALF + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES-1:0]    req_we,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                done,
  output logic [LANES*DW-1:0] rsp_rdata,
  output logic [PCW-1:0]      passes_lo,
  output logic [PCW-1:0]      passes_hi
);
  spad_state_e         state_q;
  logic [LANES-1:0]    act_q, we_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wdata_q;
  logic                half_q;
  logic [HALF-1:0]     pend_q;
  logic                done_q;
  logic [PCW-1:0]      cnt_q [2];
  logic [DW-1:0]       rsp_q [LANES];

  // lanes of the half being served
  logic [HALF*AW-1:0] cur_addr;
  logic [HALF-1:0]    cur_we;
  logic [HALF*DW-1:0] cur_wd;

  assign cur_addr = half_q ? addr_q[LANES*AW-1 -: HALF*AW] : addr_q[HALF*AW-1:0];
  assign cur_we   = half_q ? we_q[LANES-1 -: HALF]         : we_q[HALF-1:0];
  assign cur_wd   = half_q ? wdata_q[LANES*DW-1 -: HALF*DW] : wdata_q[HALF*DW-1:0];

  logic [HALF*BW-1:0] lane_bank;
  logic [HALF*RW-1:0] lane_row;
  logic [HALF-1:0]    grant;

  spad_lane_map #(.HALF(HALF), .BW(BW), .RW(RW)) i_map (
    .lane_addr (cur_addr),
    .lane_bank (lane_bank),
    .lane_row  (lane_row)
  );

  spad_pass_arbiter #(.HALF(HALF), .BW(BW)) i_arb (
    .pending   (state_q == ST_RUN ? pend_q : '0),
    .lane_bank (lane_bank),
    .grant     (grant)
  );

  // steer each granted lane onto its bank
  logic [NBANKS-1:0]    bk_we;
  logic [NBANKS*RW-1:0] bk_row;
  logic [NBANKS*DW-1:0] bk_wdata;
  logic [NBANKS*DW-1:0] bk_rdata;

  always_comb begin
    bk_we    = '0;
    bk_row   = '0;
    bk_wdata = '0;
    for (int b = 0; b < NBANKS; b++) begin
      for (int l = 0; l < HALF; l++) begin
        if (grant[l] && (lane_bank[l*BW +: BW] == BW'(b))) begin
          bk_we[b]             = cur_we[l];
          bk_row[b*RW +: RW]   = lane_row[l*RW +: RW];
          bk_wdata[b*DW +: DW] = cur_wd[l*DW +: DW];
        end
      end
    end
  end

  spad_bank_array #(.NBANKS(NBANKS), .DEPTH(DEPTH), .DW(DW)) i_banks (
    .clk      (clk),
    .bk_we    (bk_we),
    .bk_row   (bk_row),
    .bk_wdata (bk_wdata),
    .bk_rdata (bk_rdata)
  );

  // each lane picks up the word of its own bank
  logic [DW-1:0] lane_rd [HALF];
  for (genvar l = 0; l < HALF; l++) begin : g_rd
    assign lane_rd[l] = bk_rdata[lane_bank[l*BW +: BW]*DW +: DW];
  end

  logic [HALF-1:0] pend_next;
  assign pend_next = pend_q & ~grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      act_q    <= '0;
      we_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      half_q   <= 1'b0;
      pend_q   <= '0;
      done_q   <= 1'b0;
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
      for (int i = 0; i < LANES; i++) rsp_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            act_q    <= req_active;
            we_q     <= req_we;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            pend_q   <= req_active[HALF-1:0];
            half_q   <= 1'b0;
            cnt_q[0] <= '0;
            cnt_q[1] <= '0;
            for (int i = 0; i < LANES; i++) rsp_q[i] <= '0;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (pend_q != '0) cnt_q[half_q] <= cnt_q[half_q] + PCW'(1);
          for (int l = 0; l < HALF; l++) begin
            if (grant[l] && !cur_we[l]) begin
              if (half_q) rsp_q[HALF + l] <= lane_rd[l];
              else        rsp_q[l]        <= lane_rd[l];
            end
          end
          if (pend_next == '0) begin
            if (!half_q) begin
              half_q <= 1'b1;
              pend_q <= act_q[LANES-1 -: HALF];
            end else begin
              pend_q  <= '0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else begin
            pend_q <= pend_next;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign passes_lo = cnt_q[0];
  assign passes_hi = cnt_q[1];

  for (genvar i = 0; i < LANES; i++) begin : g_rsp
    assign rsp_rdata[i*DW +: DW] = rsp_q[i];
  end
endmodule

// File: rtl/spad_checker.sv
module spad_checker #(
  parameter int HALF = 16,
  parameter int PCW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           done,
  input logic [PCW-1:0] passes_lo,
  input logic [PCW-1:0] passes_hi
);
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_falls_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_pass_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (passes_lo <= PCW'(HALF)) && (passes_hi <= PCW'(HALF)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(passes_lo) && $stable(passes_hi)));
endmodule

bind banked_spad spad_checker #(.HALF(HALF), .PCW(PCW)) i_spad_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .passes_lo (passes_lo),
  .passes_hi (passes_hi)
);

// File: tb/test_banked_spad.sv
`timescale 1ns/100ps
module test_banked_spad;
  localparam int LN = 32;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LN-1:0] req_active = '0;
  logic [LN-1:0] req_we = '0;
  logic [LN*AW-1:0] req_addr = '0;
  logic [LN*32-1:0] req_wdata = '0;
  logic done;
  logic [LN*32-1:0] rsp_rdata;
  logic [4:0] passes_lo, passes_hi;

  always #2.5 clk = ~clk;

  banked_spad i_banked_spad (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rsp_rdata(rsp_rdata),
    .passes_lo(passes_lo), .passes_hi(passes_hi)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] t_act, t_we;
  int          t_addr [LN];
  logic [31:0] t_wd   [LN];
  logic [31:0] mdl    [256];
  logic [31:0] exp_rd [LN];

  task automatic check(string req, string what, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic clear_req();
    t_act = '0;
    t_we  = '0;
    for (int l = 0; l < LN; l++) begin
      t_addr[l] = 0;
      t_wd[l]   = '0;
    end
  endtask

  function automatic int exp_passes(int h);
    int cnt [16];
    int m = 0;
    foreach (cnt[i]) cnt[i] = 0;
    for (int l = 0; l < 16; l++) begin
      int ln = h*16 + l;
      if (t_act[ln]) begin
        int b = (t_addr[ln] >> 2) % 16;
        cnt[b]++;
        if (cnt[b] > m) m = cnt[b];
      end
    end
    return m;
  endfunction

  // lanes served in rising order give the same per-word result as the replay
  task automatic model_apply();
    for (int l = 0; l < LN; l++) begin
      int w = (t_addr[l] >> 2) & 255;
      exp_rd[l] = '0;
      if (t_act[l]) begin
        if (t_we[l]) mdl[w] = t_wd[l];
        else         exp_rd[l] = mdl[w];
      end
    end
  endtask

  task automatic run_req(string req, output int p0, output int p1);
    int lat_exp, cnt, first_bad;
    bit ready_bad;
    p0 = exp_passes(0);
    p1 = exp_passes(1);
    lat_exp = (p0 > 0 ? p0 : 1) + (p1 > 0 ? p1 : 1) + 1;
    model_apply();
    @(negedge clk);
    req_active = t_act;
    req_we     = t_we;
    for (int l = 0; l < LN; l++) begin
      req_addr[l*AW +: AW]  = t_addr[l][AW-1:0];
      req_wdata[l*32 +: 32] = t_wd[l];
    end
    req_valid = 1'b1;
    @(posedge clk);
    cnt = 0;
    ready_bad = 0;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      cnt++;
      if (done) break;
      if (req_ready) ready_bad = 1;
      if (cnt > 100) break;
      @(negedge clk);
    end
    check("R7", "done latency", cnt, lat_exp);
    check("R7", "ready low while busy", ready_bad, 0);
    check(req, "passes_lo", passes_lo, p0);
    check(req, "passes_hi", passes_hi, p1);
    first_bad = -1;
    for (int l = LN-1; l >= 0; l--)
      if (rsp_rdata[l*32 +: 32] !== exp_rd[l]) first_bad = l;
    if (first_bad < 0) check(req, "read data", 0, 0);
    else check(req, $sformatf("read data lane %0d", first_bad),
               rsp_rdata[first_bad*32 +: 32], exp_rd[first_bad]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R7", "ready after reset", req_ready, 1);
    check("R7", "done after reset", done, 0);
    check("R9", "passes after reset", {passes_lo, passes_hi}, 0);
  endtask

  // R1 R2: fill all 256 words with stride-1 writes, byte offset varied
  task automatic t_fill();
    int p0, p1;
    for (int blk = 0; blk < 8; blk++) begin
      clear_req();
      t_act = '1;
      t_we  = '1;
      for (int l = 0; l < LN; l++) begin
        int w = blk*32 + l;
        t_addr[l] = w*4 + (l % 4);
        t_wd[l]   = 32'hA500_0000 ^ (w * 32'h0101_0107);
      end
      run_req("R2", p0, p1);
    end
  endtask

  // R1: read every word back through a different byte offset
  task automatic t_readback();
    int p0, p1;
    for (int blk = 0; blk < 8; blk++) begin
      clear_req();
      t_act = '1;
      for (int l = 0; l < LN; l++) t_addr[l] = (blk*32 + l)*4 + 3 - (l % 4);
      run_req("R1", p0, p1);
    end
  endtask

  // R8 R3: strided reads
  task automatic t_strides();
    int strides [7] = '{1, 3, 5, 2, 4, 8, 16};
    int p0, p1;
    foreach (strides[k]) begin
      int s = strides[k];
      clear_req();
      t_act = '1;
      for (int l = 0; l < LN; l++) t_addr[l] = ((s*l + k) & 255) * 4;
      run_req("R8", p0, p1);
      if (s % 2 == 1) check("R8", $sformatf("odd stride %0d one pass", s), passes_lo, 1);
      else check("R8", $sformatf("even stride %0d gcd passes", s), passes_lo, (s > 16) ? 16 : s);
    end
  endtask

  // R3: four byte lanes per word collide four ways
  task automatic t_byte_lanes();
    int p0, p1;
    clear_req();
    for (int l = 0; l < 16; l++) begin
      t_act[l]  = 1'b1;
      t_addr[l] = 40*4 + l;
    end
    run_req("R3", p0, p1);
    check("R3", "byte lanes four passes", passes_lo, 4);
    check("R5", "empty high half zero passes", passes_hi, 0);
  endtask

  // R4: mixed reads and writes of one word inside a half
  task automatic t_lane_order();
    int p0, p1;
    clear_req();
    t_act[1] = 1; t_addr[1] = 77*4;                              // old value
    t_act[3] = 1; t_we[3] = 1; t_addr[3] = 77*4+1; t_wd[3] = 32'h1111_1111;
    t_act[6] = 1; t_addr[6] = 77*4+2;                            // sees lane 3
    t_act[9] = 1; t_we[9] = 1; t_addr[9] = 77*4+3; t_wd[9] = 32'h2222_2222;
    t_act[12] = 1; t_addr[12] = 93*4;                            // same bank, other row
    t_act[14] = 1; t_addr[14] = 77*4;                            // sees lane 9
    run_req("R4", p0, p1);
    check("R4", "lane 14 sees last write", rsp_rdata[14*32 +: 32], 32'h2222_2222);
    check("R4", "lane 6 sees lane 3 write", rsp_rdata[6*32 +: 32], 32'h1111_1111);
  endtask

  // R5: inactive lanes neither collide nor write
  task automatic t_inactive();
    int p0, p1;
    clear_req();
    t_act[0] = 1; t_addr[0] = 5*4;
    for (int l = 1; l < 8; l++) begin
      t_we[l] = 1; t_addr[l] = 21*4; t_wd[l] = 32'hDEAD_0000 + l;
    end
    for (int l = 16; l < 32; l++) begin
      t_we[l] = 1; t_addr[l] = 21*4; t_wd[l] = 32'hBEEF_0000 + l;
    end
    run_req("R5", p0, p1);
    check("R5", "inactive lanes no collision", passes_lo, 1);
    check("R5", "inactive lane data zero", rsp_rdata[3*32 +: 32], 0);
    clear_req();
    t_act[20] = 1; t_addr[20] = 21*4;
    run_req("R5", p0, p1);
    check("R5", "word untouched by inactive writes", rsp_rdata[20*32 +: 32], mdl[21]);
    check("R5", "empty low half zero passes", passes_lo, 0);
  endtask

  // R6: high half sees low half write; collisions in both halves
  task automatic t_half_order();
    int p0, p1;
    clear_req();
    t_act[15] = 1; t_we[15] = 1; t_addr[15] = 130*4; t_wd[15] = 32'h6060_6060;
    t_act[2] = 1; t_addr[2] = 146*4;
    t_act[16] = 1; t_addr[16] = 130*4;
    t_act[17] = 1; t_addr[17] = 162*4;
    t_act[18] = 1; t_addr[18] = 178*4;
    run_req("R6", p0, p1);
    check("R6", "high half reads low half write", rsp_rdata[16*32 +: 32], 32'h6060_6060);
    check("R3", "high half three-way", passes_hi, 3);
  endtask

  // R9: outputs hold while idle
  task automatic t_hold();
    logic [LN*32-1:0] snap;
    logic [9:0] psnap;
    snap  = rsp_rdata;
    psnap = {passes_lo, passes_hi};
    repeat (7) @(negedge clk);
    check("R9", "read data held", (snap == rsp_rdata) ? 1 : 0, 1);
    check("R9", "pass counts held", {passes_lo, passes_hi}, psnap);
    check("R9", "write lane returns zero", rsp_rdata[15*32 +: 32] == 0 ? 1 : 0, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 40000);
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    summary();
  end

  initial begin
    foreach (mdl[i]) mdl[i] = '0;
    clear_req();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_readback();
    t_strides();
    t_byte_lanes();
    t_lane_order();
    t_inactive();
    t_half_order();
    t_hold();
    summary();
  end
endmodule